// File: doc/BRIEF.md
# Target Address-Range Traffic Monitor

This block watches the request stream that flows from the memory fabric toward a root complex. Each request targets either a device BAR window or a CXL memory window. For every request that passes a programmable filter, it counts the event: read requests, write requests, read bytes and write bytes. A fifth counter advances on every clock. Software reads these counts and derives bandwidth and request rate over a measured interval. Whether a request is BAR or CXL traffic is decided upstream and arrives as a flag.

The filter has two modes. In root-port mode, an 8-bit mask picks the destination root ports of interest. This mode only accepts BAR traffic, so CXL requests never count. In address mode, a request qualifies when its address agrees with a base value on every bit that a mask selects. This mode applies to both traffic kinds and ignores the root-port mask. The filter decision is combinational and is registered into the counters on the same clock edge. A small word-addressed register port configures the filter and reads the counters back.

Top module: `tgt_traffic_mon`

## Requirements
- R1: After reset all counters read zero, the root-port mask is 0xFF and address mode is off, so BAR traffic to every root port is counted.
- R2: With address mode off, a valid BAR request is counted only if bit `req_port_i` of the root-port mask is set.
- R3: With address mode off, a request flagged as CXL (`req_cxl_i`=1) is never counted, whatever its port.
- R4: With address mode on, a valid request of either kind is counted exactly when `(addr & mask) == (base & mask)`, and the root-port mask has no effect. With base 0x10000 and mask 0xFFF00, addresses 0x10000 to 0x100FF match and 0x10100 does not.
- R5: A counted read adds 1 to the read-request counter and `req_bytes_i` to the read-byte counter. A counted write does the same for the write counters. A single request never changes both request counters.
- R6: The cycle counter advances by one on every clock, independent of traffic and filter.
- R7: A request presented in one cycle is visible in the counters after the next rising clock edge, and not before it.
- R8: A register write to either word of a counter clears that counter to zero on that edge. Clearing takes priority over an increment in the same cycle.
- R9: The register map uses word offsets. Offset 0 is control: bit 0 is address mode, bits 15:8 are the root-port mask, and all other bits read 0. Offset 1 holds base[31:0] and offset 2 holds base[47:32]. Offset 3 holds mask[31:0] and offset 4 holds mask[47:32]. Counter k occupies offset 8+2k (bits 31:0) and offset 9+2k (bits 47:32), with k = 0 read requests, 1 write requests, 2 read bytes, 3 write bytes, 4 cycles. Configuration reads return what was written, truncated to the field width. Unmapped offsets read 0.
- R10: When `req_valid_i` is low, the other request inputs have no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| req_addr_i | input | 48 | Request target address |
| req_cxl_i | input | 1 | 1 = CXL memory traffic, 0 = BAR traffic |
| req_port_i | input | 3 | Destination root-port index |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bytes_i | input | BYTES_W (12) | Bytes carried by the request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |

## Verification
The filter state shows up as a counter value, so a fault shows up only through counts. If the port-mask bit index is wrong, or the CXL exclusion is missing, a read-request or byte counter is off by exactly the offending request one cycle later. If the address compare is wrong, the error appears only for addresses on the edges of the masked window, such as 0x100FF, 0x10100, or a differing bit above the mask. A wrong increment path shows as a byte total that no longer equals the sum of the accepted sizes. A cycle counter with a stuck or doubled step becomes visible over a known run of clocks.

// File: rtl/tgt_mon_pkg.sv
package tgt_mon_pkg;
  localparam int ADDR_W      = 48;
  localparam int NUM_PORTS   = 8;
  localparam int PORT_W      = $clog2(NUM_PORTS);
  localparam int DATA_W      = 32;
  localparam int REG_AW      = 5;
  localparam int NUM_EV      = 5;

  localparam int EV_RD_REQ   = 0;
  localparam int EV_WR_REQ   = 1;
  localparam int EV_RD_BYTES = 2;
  localparam int EV_WR_BYTES = 3;
  localparam int EV_CYCLES   = 4;

  localparam int OFF_CTRL    = 0;
  localparam int OFF_BASE_LO = 1;
  localparam int OFF_BASE_HI = 2;
  localparam int OFF_MASK_LO = 3;
  localparam int OFF_MASK_HI = 4;
  localparam int OFF_CNT     = 8;
  localparam int CTRL_PM_LSB = 8;

  typedef struct packed {
    logic                 addr_en;
    logic [NUM_PORTS-1:0] port_mask;
    logic [ADDR_W-1:0]    base;
    logic [ADDR_W-1:0]    mask;
  } cfg_t;
endpackage

// File: rtl/tgt_filter.sv
module tgt_filter
  import tgt_mon_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cxl_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              hit_o
);
  logic addr_hit;
  logic port_hit;

  // bits outside the mask are don't-care
  assign addr_hit = ((addr_i ^ cfg_i.base) & cfg_i.mask) == '0;
  // port selection is defined for BAR traffic only
  assign port_hit = !cxl_i && cfg_i.port_mask[port_i];
  assign hit_o    = valid_i && (cfg_i.addr_en ? addr_hit : port_hit);
endmodule

// File: rtl/tgt_counter.sv
module tgt_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_en_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (clr_i)    cnt_o <= '0;
    else if (inc_en_i) cnt_o <= cnt_o + inc_i;
  end

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/tgt_regs.sv
module tgt_regs
  import tgt_mon_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [REG_AW-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [NUM_EV-1:0][CNT_W-1:0] cnt_i,
  output cfg_t                         cfg_o,
  output logic [NUM_EV-1:0]            clr_o,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int AHI_W = ADDR_W - DATA_W;
  localparam int CHI_W = CNT_W - DATA_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.addr_en   <= 1'b0;
      cfg_o.port_mask <= '1;
      cfg_o.base      <= '0;
      cfg_o.mask      <= '0;
    end else if (we_i) begin
      case (int'(addr_i))
        OFF_CTRL: begin
          cfg_o.addr_en   <= wdata_i[0];
          cfg_o.port_mask <= wdata_i[CTRL_PM_LSB +: NUM_PORTS];
        end
        OFF_BASE_LO: cfg_o.base[DATA_W-1:0]      <= wdata_i;
        OFF_BASE_HI: cfg_o.base[ADDR_W-1:DATA_W] <= wdata_i[AHI_W-1:0];
        OFF_MASK_LO: cfg_o.mask[DATA_W-1:0]      <= wdata_i;
        OFF_MASK_HI: cfg_o.mask[ADDR_W-1:DATA_W] <= wdata_i[AHI_W-1:0];
        default: ;
      endcase
    end
  end

  // either word of a counter pair clears it
  for (genvar k = 0; k < NUM_EV; k++) begin : g_clr
    assign clr_o[k] = we_i && (addr_i[REG_AW-1:1] == (REG_AW-1)'(OFF_CNT/2 + k));
  end

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      OFF_CTRL: begin
        rdata_o[0] = cfg_o.addr_en;
        rdata_o[CTRL_PM_LSB +: NUM_PORTS] = cfg_o.port_mask;
      end
      OFF_BASE_LO: rdata_o = cfg_o.base[DATA_W-1:0];
      OFF_BASE_HI: rdata_o = DATA_W'(cfg_o.base[ADDR_W-1:DATA_W]);
      OFF_MASK_LO: rdata_o = cfg_o.mask[DATA_W-1:0];
      OFF_MASK_HI: rdata_o = DATA_W'(cfg_o.mask[ADDR_W-1:DATA_W]);
      default: begin
        for (int k = 0; k < NUM_EV; k++) begin
          if (addr_i[REG_AW-1:1] == (REG_AW-1)'(OFF_CNT/2 + k))
            rdata_o = addr_i[0] ? DATA_W'(cnt_i[k][CNT_W-1:DATA_W])
                                : cnt_i[k][DATA_W-1:0];
        end
      end
    endcase
  end

  assert_ctrl_rb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_AW'(OFF_CTRL)) |=>
      cfg_o.port_mask == $past(wdata_i[CTRL_PM_LSB +: NUM_PORTS]));
  if (CHI_W < 1) begin : g_bad_w
    initial $error("CNT_W must exceed DATA_W");
  end
endmodule

// File: rtl/tgt_traffic_mon.sv
module tgt_traffic_mon
  import tgt_mon_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int BYTES_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_cxl_i,
  input  logic [PORT_W-1:0]  req_port_i,
  input  logic               req_write_i,
  input  logic [BYTES_W-1:0] req_bytes_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o
);
  cfg_t                         cfg;
  logic                         hit;
  logic [NUM_EV-1:0]            cnt_clr;
  logic [NUM_EV-1:0]            inc_en;
  logic [NUM_EV-1:0][CNT_W-1:0] inc;
  logic [NUM_EV-1:0][CNT_W-1:0] cnt;

  tgt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (cnt),
    .cfg_o   (cfg),
    .clr_o   (cnt_clr),
    .rdata_o (reg_rdata_o)
  );

  tgt_filter u_filter (
    .cfg_i   (cfg),
    .valid_i (req_valid_i),
    .addr_i  (req_addr_i),
    .cxl_i   (req_cxl_i),
    .port_i  (req_port_i),
    .hit_o   (hit)
  );

  always_comb begin
    inc_en[EV_RD_REQ]   = hit && !req_write_i;
    inc_en[EV_WR_REQ]   = hit &&  req_write_i;
    inc_en[EV_RD_BYTES] = hit && !req_write_i;
    inc_en[EV_WR_BYTES] = hit &&  req_write_i;
    inc_en[EV_CYCLES]   = 1'b1;
    inc[EV_RD_REQ]      = CNT_W'(1);
    inc[EV_WR_REQ]      = CNT_W'(1);
    inc[EV_RD_BYTES]    = CNT_W'(req_bytes_i);
    inc[EV_WR_BYTES]    = CNT_W'(req_bytes_i);
    inc[EV_CYCLES]      = CNT_W'(1);
  end

  for (genvar k = 0; k < NUM_EV; k++) begin : g_cnt
    tgt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (cnt_clr[k]),
      .inc_en_i (inc_en[k]),
      .inc_i    (inc[k]),
      .cnt_o    (cnt[k])
    );
  end

  assert_cxl_excluded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_cxl_i && !cfg.addr_en && !(|cnt_clr)) |=>
      ($stable(cnt[EV_RD_REQ]) && $stable(cnt[EV_WR_REQ])));

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !(|cnt_clr)) |=>
      ($stable(cnt[EV_RD_REQ]) && $stable(cnt[EV_WR_REQ]) &&
       $stable(cnt[EV_RD_BYTES]) && $stable(cnt[EV_WR_BYTES])));

  assert_single_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|cnt_clr) |=> !(!$stable(cnt[EV_RD_REQ]) && !$stable(cnt[EV_WR_REQ])));

  assert_cycle_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clr[EV_CYCLES] |=> cnt[EV_CYCLES] == CNT_W'($past(cnt[EV_CYCLES]) + 1'b1));
endmodule

// File: tb/tgt_traffic_mon_test.sv
module tgt_traffic_mon_test;
  localparam longint M48 = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_addr = '0;
  logic        req_cxl = 1'b0;
  logic [2:0]  req_port = '0;
  logic        req_write = 1'b0;
  logic [11:0] req_bytes = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bit          m_en;
  logic [7:0]  m_pm;
  longint      m_base, m_mask;
  longint      m_cnt [4];

  always #4 clk = ~clk;

  tgt_traffic_mon uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_cxl_i(req_cxl),
    .req_port_i(req_port), .req_write_i(req_write), .req_bytes_i(req_bytes),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata)
  );

  function automatic bit exp_hit(longint a, bit cxl, int port);
    if (m_en) return ((a ^ m_base) & m_mask & M48) == 0;
    return !cxl && m_pm[port];
  endfunction

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[4:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a[4:0];
    #1 d = reg_rdata;
  endtask

  task automatic rd_cnt(int k, output longint v);
    logic [31:0] lo, hi;
    rd_reg(8 + 2*k, lo);
    rd_reg(9 + 2*k, hi);
    v = {16'h0, hi[15:0], lo};
  endtask

  task automatic set_cfg(bit en, logic [7:0] pm, longint base, longint mask);
    wr_reg(0, {16'h0, pm, 7'h0, en});
    wr_reg(1, base[31:0]);
    wr_reg(2, {16'h0, base[47:32]});
    wr_reg(3, mask[31:0]);
    wr_reg(4, {16'h0, mask[47:32]});
    m_en = en; m_pm = pm; m_base = base & M48; m_mask = mask & M48;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) begin
      wr_reg(8 + 2*k, 32'h0);
      m_cnt[k] = 0;
    end
  endtask

  task automatic send(longint a, bit cxl, int port, bit wr, int bytes);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[47:0]; req_cxl = cxl;
    req_port = port[2:0]; req_write = wr; req_bytes = bytes[11:0];
    if (exp_hit(a, cxl, port)) begin
      m_cnt[wr ? 1 : 0] = (m_cnt[wr ? 1 : 0] + 1) & M48;
      m_cnt[wr ? 3 : 2] = (m_cnt[wr ? 3 : 2] + bytes) & M48;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_cnts(string tag, longint rq, longint wq, longint rb, longint wb);
    longint v;
    rd_cnt(0, v); check({tag, " rd_req"}, v, rq);
    rd_cnt(1, v); check({tag, " wr_req"}, v, wq);
    rd_cnt(2, v); check({tag, " rd_bytes"}, v, rb);
    rd_cnt(3, v); check({tag, " wr_bytes"}, v, wb);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(7331);
    m_en = 0; m_pm = 8'hFF; m_base = 0; m_mask = 0;
    for (int k = 0; k < 4; k++) m_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(0, d); check("R1 ctrl", d, 32'h0000FF00);
    expect_cnts("R1", 0, 0, 0, 0);

    // R9 register readback, truncation
    wr_reg(1, 32'h89ABCDEF); rd_reg(1, d); check("R9 base_lo", d, 32'h89ABCDEF);
    wr_reg(2, 32'hFFFF4567); rd_reg(2, d); check("R9 base_hi", d, 32'h00004567);
    wr_reg(4, 32'h1234ABCD); rd_reg(4, d); check("R9 mask_hi", d, 32'h0000ABCD);
    wr_reg(0, 32'hFFFFA501); rd_reg(0, d); check("R9 ctrl", d, 32'h0000A501);
    rd_reg(6, d); check("R9 unmapped", d, 0);

    // R2 root-port mask
    set_cfg(0, 8'h05, 0, 0); clear_all();
    send(48'h1000, 0, 0, 0, 64);
    send(48'h1000, 0, 1, 0, 32);
    send(48'h2000, 0, 2, 1, 16);
    send(48'h3000, 0, 7, 1, 8);
    idle();
    expect_cnts("R2", 1, 1, 64, 16);

    // R3 CXL excluded in port mode
    set_cfg(0, 8'hFF, 0, 0); clear_all();
    send(48'h4000, 1, 3, 0, 100);
    send(48'h4000, 1, 3, 1, 200);
    send(48'h4000, 0, 3, 0, 4);
    idle();
    expect_cnts("R3", 1, 0, 4, 0);

    // R4 address window, port mask ignored
    set_cfg(1, 8'h00, 48'h10000, 48'hFFF00); clear_all();
    send(48'h10000, 0, 0, 0, 1);
    send(48'h100FF, 1, 5, 0, 2);
    send(48'h10100, 0, 0, 0, 4);
    send(48'h0FFFF, 0, 0, 0, 8);
    send(48'h10080, 1, 2, 1, 16);
    send(48'h800000010000, 0, 6, 0, 32);
    idle();
    expect_cnts("R4", 3, 1, 35, 16);

    // R10 invalid requests ignored
    @(negedge clk);
    req_valid = 1'b0; req_addr = 48'h10000; req_write = 1'b0; req_bytes = 12'd99;
    repeat (3) @(negedge clk);
    req_write = 1'b1;
    repeat (3) @(negedge clk);
    expect_cnts("R10", 3, 1, 35, 16);

    // R7 one-edge latency
    @(negedge clk);
    reg_addr = 5'd8;
    req_valid = 1'b1; req_addr = 48'h10010; req_cxl = 1'b0; req_write = 1'b0; req_bytes = 12'd1;
    #1 check("R7 before edge", reg_rdata, 3);
    @(negedge clk);
    req_valid = 1'b0;
    #1 check("R7 after edge", reg_rdata, 4);

    // R8 clear via high word
    wr_reg(9, 32'h0); rd_reg(8, d); check("R8 clear rd_req", d, 0);
    rd_reg(10, d); check("R8 other kept", d, 1);

    // R6 cycle counter
    wr_reg(16, 32'h0);
    reg_addr = 5'd16;
    #1 check("R6 cyc after clear", reg_rdata, 0);
    repeat (37) @(negedge clk);
    #1 check("R6 cyc 37", reg_rdata, 37);

    // R5 random traffic against the model
    for (int r = 0; r < 4; r++) begin
      longint base, mask;
      base = {$urandom(), $urandom()} & M48;
      mask = ((r % 2) == 0) ? 64'hFFFF_FFFF_F000 : ({$urandom(), $urandom()} & M48);
      set_cfg(r[0], 8'($urandom()), base, mask);
      clear_all();
      for (int i = 0; i < 300; i++) begin
        longint a;
        a = ($urandom() % 2) ? ((base ^ ({$urandom(), $urandom()} & ~mask)) & M48)
                             : ({$urandom(), $urandom()} & M48);
        send(a, 1'($urandom()), int'($urandom() % 8), 1'($urandom()), int'($urandom() % 4096));
        if ($urandom() % 4 == 0) idle();
      end
      idle();
      expect_cnts($sformatf("R5 round %0d", r), m_cnt[0], m_cnt[1], m_cnt[2], m_cnt[3]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule